// File: doc/BRIEF.md
# TDM Channel Timeslot Router

This block sits on a bit-serial time-division frame with four eight-bit timeslots. Slot 1 carries a control channel. Slots 2 and 3 carry the two bearer channels, called LO (slot 2) and HI (slot 3). On the transmit side it shifts out a programmed control byte and a programmed bearer byte, each most significant bit first. Every bit comes with an output-enable, so any slot the block does not own is left undriven. On the receive side it assembles the control byte and one selected bearer byte from the serial input.

A frame pulse marks bit 0 of slot 0. Between pulses a position counter free-runs across the 32 bit positions. A small write-only register port sets the transmit bytes and the channel selection. The transmit bearer slot and the receive bearer slot are chosen independently of each other. Software can also issue a reset through this port that returns every transmit setting to its default.

Top module: `tdm_slot_router`

## Requirements
- R1: After `rst`, `sdout_oe`, `bear_rx_valid`, `ctrl_rx_byte` and `bear_rx_byte` are all 0. Both transmit bytes hold 8'hFF and the configuration register holds 0.
- R2: A cycle with `frame_pulse` high is bit 0 of slot 0. Each following cycle advances the position by one, with slot = position/8 and bit = position mod 8, wrapping after 32 positions. A new frame pulse realigns the count at any point.
- R3: When configuration bit 0 (control enable) is 1, slot 1 drives `sdout_oe`=1 and sends the control transmit byte (register address 0) MSB first, one bit per cycle.
- R4: When control enable is 0, `sdout_oe` stays 0 for all of slot 1.
- R5: The control byte received MSB first during slot 1 appears on `ctrl_rx_byte` in the cycle after the last bit of slot 1, whatever the transmit settings. `ctrl_rx_byte` changes at no other time.
- R6: Configuration bits 2:1 select the transmit bearer slot: 01 drives slot 2 and 10 drives slot 3. The selected slot sends the bearer transmit byte (address 3) MSB first. The other bearer slot stays undriven.
- R7: With transmit select 00 or 11, both bearer slots are undriven. Slot 0 is never driven.
- R8: When configuration bit 3 (receive enable) is 1, configuration bit 4 picks the receive slot: 0 for slot 2, 1 for slot 3. The byte received in that slot appears on `bear_rx_byte`, and `bear_rx_valid` pulses for exactly the one cycle after the slot's last bit. This selection does not depend on the transmit select.
- R9: When receive enable is 0, `bear_rx_valid` stays 0 and `bear_rx_byte` holds its value.
- R10: A write to address 2 with data bit 0 set restores both transmit bytes to 8'hFF and the configuration to 0. A write to address 2 with bit 0 clear changes nothing. Received bytes are kept in both cases.
- R11: While `sdout_oe` is 0, `sdout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Marks bit 0 of slot 0 |
| sdin | input | 1 | Serial receive data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control byte, 1 config, 2 soft reset, 3 bearer byte |
| reg_wdata | input | 8 | Register write data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Per-bit output enable for `sdout` |
| ctrl_rx_byte | output | 8 | Last received control byte |
| bear_rx_byte | output | 8 | Last received bearer byte |
| bear_rx_valid | output | 1 | One-cycle pulse when `bear_rx_byte` updates |

## Verification
Frames are run with the transmit select at each of its four codes, crossed with both receive slots. Pairing transmit on LO with receive on HI, and the reverse, shows whether the two selections really are independent. Distinct byte patterns are placed in slots 1, 2 and 3, so any mix-up in slot decoding or bit order shows up as a wrong byte. Directed cases cover soft reset with its bit set and clear, and a frame pulse that arrives early to realign the count. Seeded random register settings and serial data then cover the remaining combinations.

// File: rtl/tdm_rtr_pkg.sv
package tdm_rtr_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_SLOTS  = 4;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int POS_W      = BIT_IDX_W + SLOT_IDX_W;
    localparam int ADDR_W     = 2;

    localparam int CTRL_SLOT    = 1;
    localparam int BEAR_LO_SLOT = 2;
    localparam int BEAR_HI_SLOT = 3;

    localparam logic [BYTE_W-1:0] TX_BYTE_DEFAULT = '1;

    typedef enum logic [1:0] {
        TXB_OFF = 2'b00,
        TXB_LO  = 2'b01,
        TXB_HI  = 2'b10,
        TXB_BAD = 2'b11
    } txb_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL_TX  = 2'd0,
        RA_CONFIG   = 2'd1,
        RA_SOFT_RST = 2'd2,
        RA_BEAR_TX  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic     rx_sel_hi;
        logic     rx_en;
        txb_sel_e tx_sel;
        logic     ctrl_tx_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } pos_t;

    function automatic cfg_t cfg_default();
        return cfg_t'('0);
    endfunction

    function automatic logic msb_bit(input logic [BYTE_W-1:0] b,
                                     input logic [BIT_IDX_W-1:0] idx);
        return b[BIT_IDX_W'(BYTE_W-1) - idx];
    endfunction

    function automatic logic is_last_bit(input pos_t p);
        return p.bit_idx == BIT_IDX_W'(BYTE_W-1);
    endfunction
endpackage

// File: rtl/tdm_rtr_timing.sv
module tdm_rtr_timing
    import tdm_rtr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_pulse,
    output pos_t cur_pos
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_now;

    // The frame pulse cycle itself is position zero.
    assign pos_now = frame_pulse ? '0 : pos_q;
    assign cur_pos = pos_t'(pos_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_now + POS_W'(1);
        end
    end
endmodule

// File: rtl/tdm_rtr_regs.sv
module tdm_rtr_regs
    import tdm_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] ctrl_tx_byte,
    output logic [BYTE_W-1:0] bear_tx_byte,
    output cfg_t              cfg
);
    logic soft_rst;

    assign soft_rst = reg_wr && (reg_addr_e'(reg_addr) == RA_SOFT_RST) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_tx_byte <= TX_BYTE_DEFAULT;
            bear_tx_byte <= TX_BYTE_DEFAULT;
            cfg          <= cfg_default();
        end else if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                RA_CTRL_TX: ctrl_tx_byte <= reg_wdata;
                RA_CONFIG:  cfg          <= cfg_t'(reg_wdata[CFG_W-1:0]);
                RA_BEAR_TX: bear_tx_byte <= reg_wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/tdm_rtr_tx.sv
module tdm_rtr_tx
    import tdm_rtr_pkg::*;
(
    input  pos_t              cur_pos,
    input  cfg_t              cfg,
    input  logic [BYTE_W-1:0] ctrl_tx_byte,
    input  logic [BYTE_W-1:0] bear_tx_byte,
    output logic              sdout,
    output logic              sdout_oe
);
    logic [NUM_SLOTS-1:0] slot_drive;
    logic [BYTE_W-1:0]    slot_byte [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == CTRL_SLOT) begin : g_ctrl
            assign slot_drive[s] = cfg.ctrl_tx_en;
            assign slot_byte[s]  = ctrl_tx_byte;
        end else if (s == BEAR_LO_SLOT) begin : g_lo
            assign slot_drive[s] = (cfg.tx_sel == TXB_LO);
            assign slot_byte[s]  = bear_tx_byte;
        end else if (s == BEAR_HI_SLOT) begin : g_hi
            assign slot_drive[s] = (cfg.tx_sel == TXB_HI);
            assign slot_byte[s]  = bear_tx_byte;
        end else begin : g_idle
            assign slot_drive[s] = 1'b0;
            assign slot_byte[s]  = '0;
        end
    end

    always_comb begin
        sdout_oe = slot_drive[cur_pos.slot];
        sdout    = sdout_oe & msb_bit(slot_byte[cur_pos.slot], cur_pos.bit_idx);
    end
endmodule

// File: rtl/tdm_rtr_rx.sv
module tdm_rtr_rx
    import tdm_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pos_t              cur_pos,
    input  cfg_t              cfg,
    input  logic              sdin,
    output logic [BYTE_W-1:0] ctrl_rx_byte,
    output logic [BYTE_W-1:0] bear_rx_byte,
    output logic              bear_rx_valid
);
    logic [BYTE_W-1:0]     shift_q;
    logic [BYTE_W-1:0]     assembled;
    logic [SLOT_IDX_W-1:0] rx_slot;
    logic                  slot_end;

    assign assembled = {shift_q[BYTE_W-2:0], sdin};
    assign rx_slot   = cfg.rx_sel_hi ? SLOT_IDX_W'(BEAR_HI_SLOT) : SLOT_IDX_W'(BEAR_LO_SLOT);
    assign slot_end  = is_last_bit(cur_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q       <= '0;
            ctrl_rx_byte  <= '0;
            bear_rx_byte  <= '0;
            bear_rx_valid <= 1'b0;
        end else begin
            shift_q       <= assembled;
            bear_rx_valid <= 1'b0;
            if (slot_end && cur_pos.slot == SLOT_IDX_W'(CTRL_SLOT)) begin
                ctrl_rx_byte <= assembled;
            end
            if (slot_end && cfg.rx_en && cur_pos.slot == rx_slot) begin
                bear_rx_byte  <= assembled;
                bear_rx_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tdm_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_pulse,
    input  logic              sdin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic              sdout,
    output logic              sdout_oe,
    output logic [BYTE_W-1:0] ctrl_rx_byte,
    output logic [BYTE_W-1:0] bear_rx_byte,
    output logic              bear_rx_valid
);
    pos_t              cur_pos;
    cfg_t              cfg;
    logic [BYTE_W-1:0] ctrl_tx_byte;
    logic [BYTE_W-1:0] bear_tx_byte;

    tdm_rtr_timing u_timing (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .cur_pos     (cur_pos)
    );

    tdm_rtr_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .ctrl_tx_byte (ctrl_tx_byte),
        .bear_tx_byte (bear_tx_byte),
        .cfg          (cfg)
    );

    tdm_rtr_tx u_tx (
        .cur_pos      (cur_pos),
        .cfg          (cfg),
        .ctrl_tx_byte (ctrl_tx_byte),
        .bear_tx_byte (bear_tx_byte),
        .sdout        (sdout),
        .sdout_oe     (sdout_oe)
    );

    tdm_rtr_rx u_rx (
        .clk           (clk),
        .rst           (rst),
        .cur_pos       (cur_pos),
        .cfg           (cfg),
        .sdin          (sdin),
        .ctrl_rx_byte  (ctrl_rx_byte),
        .bear_rx_byte  (bear_rx_byte),
        .bear_rx_valid (bear_rx_valid)
    );
endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk
    import tdm_rtr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_pulse,
    input logic              sdout,
    input logic              sdout_oe,
    input logic [BYTE_W-1:0] ctrl_rx_byte,
    input logic [BYTE_W-1:0] bear_rx_byte,
    input logic              bear_rx_valid
);
    // Independent position tracker built from the frame pulse alone.
    logic [POS_W-1:0] trk_q;
    logic [POS_W-1:0] trk_now;
    logic [POS_W-1:0] prev_q;

    assign trk_now = frame_pulse ? '0 : trk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q  <= '0;
            prev_q <= '0;
        end else begin
            trk_q  <= trk_now + POS_W'(1);
            prev_q <= trk_now;
        end
    end

    assert_quiet_line_R11: assert property (@(posedge clk) disable iff (rst)
        !sdout_oe |-> !sdout);

    assert_slot0_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (trk_now[POS_W-1 -: SLOT_IDX_W] == '0) |-> !sdout_oe);

    assert_ctrl_rx_timing_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_rx_byte) |-> (prev_q == POS_W'(CTRL_SLOT*BYTE_W + BYTE_W - 1)));

    assert_valid_slot_R8: assert property (@(posedge clk) disable iff (rst)
        bear_rx_valid |-> (prev_q[BIT_IDX_W-1:0] == '1 && prev_q[POS_W-1]));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        bear_rx_valid |=> !bear_rx_valid);

    assert_bear_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bear_rx_valid |-> $stable(bear_rx_byte));
endmodule

bind tdm_slot_router tdm_slot_router_chk u_chk (.*);

// File: tb/tb_tdm_slot_router.sv
module tb_tdm_slot_router;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_pulse = 1'b0;
    logic       sdin = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       sdout, sdout_oe, bear_rx_valid;
    logic [7:0] ctrl_rx_byte, bear_rx_byte;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    // Bench model of the programmed state
    logic [7:0] m_ctrl = 8'hFF, m_btx = 8'hFF;
    logic       m_en = 0, m_rxen = 0, m_rxsel = 0;
    logic [1:0] m_txsel = 2'b00;
    // Expected registered outputs
    logic [7:0] e_crx = 0, e_bbyte = 0, rxsh = 0;
    logic       e_valid = 0;
    int         bpos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_router dut (
        .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .sdin(sdin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .sdout(sdout), .sdout_oe(sdout_oe), .ctrl_rx_byte(ctrl_rx_byte),
        .bear_rx_byte(bear_rx_byte), .bear_rx_valid(bear_rx_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_oe(input int pos);
        int s = pos / 8;
        if (s == 1) return m_en;
        if (s == 2) return m_txsel == 2'b01;
        if (s == 3) return m_txsel == 2'b10;
        return 1'b0;
    endfunction

    function automatic logic exp_bit(input int pos);
        int s = pos / 8;
        int b = pos % 8;
        if (!exp_oe(pos)) return 1'b0;
        return (s == 1) ? m_ctrl[7-b] : m_btx[7-b];
    endfunction

    // One bit-clock cycle; called at a falling edge, returns at the next.
    task automatic step(input logic fp, input logic din, input logic wr,
                        input logic [1:0] a, input logic [7:0] d);
        int cur;
        frame_pulse = fp; sdin = din; reg_wr = wr; reg_addr = a; reg_wdata = d;
        #1;
        cur = fp ? 0 : bpos;
        chk("R5 ctrl_rx_byte", ctrl_rx_byte, e_crx);
        chk("R8/R9 bear_rx_valid", bear_rx_valid, e_valid);
        chk("R8/R9 bear_rx_byte", bear_rx_byte, e_bbyte);
        chk("R2/R3/R4/R6/R7 sdout_oe", sdout_oe, exp_oe(cur));
        chk("R2/R3/R6/R11 sdout", sdout, exp_bit(cur));
        rxsh = {rxsh[6:0], din};
        e_valid = 1'b0;
        if (cur == 15) e_crx = rxsh;
        if (m_rxen && ((!m_rxsel && cur == 23) || (m_rxsel && cur == 31))) begin
            e_valid = 1'b1;
            e_bbyte = rxsh;
        end
        if (wr) begin
            case (a)
                2'd0: m_ctrl = d;
                2'd1: begin m_en = d[0]; m_txsel = d[2:1]; m_rxen = d[3]; m_rxsel = d[4]; end
                2'd2: if (d[0]) begin
                          m_ctrl = 8'hFF; m_btx = 8'hFF; m_en = 0;
                          m_txsel = 0; m_rxen = 0; m_rxsel = 0;
                      end
                default: m_btx = d;
            endcase
        end
        bpos = (cur + 1) % 32;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        step(1'b0, 1'($urandom % 2), 1'b1, a, d);
    endtask

    task automatic cfg(input logic en, input logic [1:0] txs, input logic rxen, input logic rxs);
        wr_reg(2'd1, {3'b000, rxs, rxen, txs, en});
    endtask

    task automatic run_frame(input logic [7:0] c_in, input logic [7:0] lo_in, input logic [7:0] hi_in);
        for (int i = 0; i < 32; i++) begin
            logic din;
            case (i / 8)
                1:       din = c_in[7 - i % 8];
                2:       din = lo_in[7 - i % 8];
                3:       din = hi_in[7 - i % 8];
                default: din = 1'($urandom % 2);
            endcase
            step(i == 0, din, 1'b0, 2'd0, 8'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 sdout_oe", sdout_oe, 0);
        chk("R1 bear_rx_valid", bear_rx_valid, 0);
        chk("R1 ctrl_rx_byte", ctrl_rx_byte, 0);
        chk("R1 bear_rx_byte", bear_rx_byte, 0);
        @(negedge clk);
        // Defaults: nothing driven (R1, R7), receive disabled (R9)
        run_frame(8'h81, 8'h42, 8'h24);
        // R1: control byte default of all ones visible once enabled
        cfg(1, 2'b00, 0, 0);
        run_frame(8'h5A, 8'h11, 8'h22);
        // R6/R8: transmit LO while receiving HI
        wr_reg(2'd0, 8'hA5);
        wr_reg(2'd3, 8'h3C);
        cfg(1, 2'b01, 1, 1);
        run_frame(8'hC3, 8'h96, 8'h69);
        // R6/R8: transmit HI while receiving LO
        cfg(1, 2'b10, 1, 0);
        run_frame(8'h0F, 8'hE1, 8'h1E);
        // R7: code 11 drives neither bearer slot
        cfg(1, 2'b11, 1, 1);
        run_frame(8'hF0, 8'h77, 8'h88);
        // R4/R9: control disabled, receive disabled
        cfg(0, 2'b01, 0, 1);
        run_frame(8'h12, 8'h34, 8'h56);
        // R10: soft reset with bit 0 clear has no effect, then with bit 0 set
        wr_reg(2'd2, 8'hFE);
        cfg(1, 2'b10, 1, 1);
        run_frame(8'h9C, 8'hAB, 8'hCD);
        wr_reg(2'd2, 8'h01);
        run_frame(8'h3E, 8'h5D, 8'h7B);
        cfg(1, 2'b01, 1, 0);
        run_frame(8'h44, 8'h55, 8'h66);
        // R2: early frame pulse realigns mid-frame
        for (int i = 0; i < 13; i++) step(i == 0, 1'($urandom % 2), 1'b0, 2'd0, 8'd0);
        run_frame(8'hD2, 8'h2D, 8'hB4);
        step(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
        run_frame(8'h6A, 8'hA6, 8'h5B);
        // Random mix of settings and data
        for (int it = 0; it < 60; it++) begin
            int nw = $urandom % 4;
            for (int w = 0; w < nw; w++)
                wr_reg(2'($urandom % 4), 8'($urandom % 256) & ((($urandom % 8) == 0) ? 8'hFF : 8'hFE));
            run_frame(8'($urandom), 8'($urandom), 8'($urandom));
        end
        step(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule